// File: doc/BRIEF.md
# Word-Serial Rotation Cipher Decryptor

This block recovers one 64-bit plaintext block, held as four 16-bit words, from the output of a 20-round cipher built on data-dependent rotations. An upstream encryptor sends a one-cycle start pulse. The four ciphertext words then arrive on consecutive cycles. Round keys stream in one per cycle, highest index first. The block removes the closing whitening keys and runs the inverse rounds from round 20 down to round 1, two cycles per round. It then removes the opening whitening keys and shifts the four recovered words out on its plaintext port.

The recovered block moves into a separate four-word drain register. A new block can therefore be accepted in the same cycle that ready returns, and the previous block's words still drain out intact. Key generation happens elsewhere. The block only consumes keys in the order it is given them.

The controller has nine states. IDLE waits for start. LOAD_A, LOAD_B, LOAD_C and LOAD_D capture the ciphertext words. RND_C and RND_A are the two halves of one inverse round. FIN_D and FIN_B apply the last two keys. The transitions are:
- IDLE goes to LOAD_A on start.
- LOAD_A, LOAD_B, LOAD_C and LOAD_D follow one another, and LOAD_D goes to RND_C.
- RND_C always goes to RND_A.
- RND_A goes back to RND_C while rounds remain, and goes to FIN_D after round 1.
- FIN_D goes to FIN_B.
- FIN_B goes to LOAD_A if start is high, and to IDLE otherwise.

Top module: `rot_block_decryptor`

## Requirements
- R1: A synchronous reset clears every data register and the drain buffer and returns the controller to IDLE. In the cycle after reset, ready is 1 and the plaintext output is 0, and a reset in the middle of a block abandons that block.
- R2: Start is accepted only while ready is 1. Counting the start cycle as cycle 0, the ciphertext words are taken in cycles 1, 2, 3 and 4 in the order A, B, C, D, where A is the most significant 16 bits of the block.
- R3: Round keys are taken one per cycle from cycle 3 through cycle 46, in descending order from S[43] to S[0].
- R4: The output block equals the plaintext that the encryptor was given, bit for bit, for any key set. The inverse uses subtraction modulo 2^16, a rotate right by the low 4 bits of t or u, and XOR. Here t and u are the product x*(2x+1) of the rotated B or D word, rotated left by 4.
- R5: Ready is 0 from cycle 1 through cycle 45 after an accepted start, and it is 1 again in cycle 46, the cycle in which S[0] is taken.
- R6: The recovered words appear on the plaintext output in cycles 47, 48, 49 and 50, in the order A, B, C, D.
- R7: In every cycle in which no recovered word is being presented, the plaintext output is 0.
- R8: A start pulse while ready is 0 has no effect on timing or results.
- R9: A start accepted in cycle 46 begins the next block at once, and the first block's four words still emerge unchanged in cycles 47 to 50.
- R10: Values on the ciphertext and key inputs outside their slots are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_in | input | 1 | One-cycle pulse; ciphertext follows in the next four cycles |
| cipher_in | input | 16 | Ciphertext word, A then B then C then D |
| rkey_in | input | 16 | Round key word, descending index |
| plain_out | output | 16 | Recovered plaintext word, 0 when idle |
| ready_out | output | 1 | High when a new block may be started |

## Verification
The bench builds ciphertext with its own forward cipher and checks that the block returns the original words. It uses all-zero keys, all-ones keys, all-zero and all-ones plaintext, and patterns with mixed bits. If the key order were off by one, or a rotation went in the wrong direction, every word would come out garbled. A back-to-back start in the cycle ready rises is aimed at a design that reuses the working registers for output, which would corrupt the first block's B, C and D words. A start pulse in the middle of a block, and junk on the data inputs outside their slots, catch a controller that restarts or a datapath that loads at the wrong time; such a design would shift ready and change the results. A reset in the middle of a block must leave ready high and the output quiet, and the next block must still decrypt correctly.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    // Controller states; the datapath decodes them directly.
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_LOAD_A = 4'd1,
        ST_LOAD_B = 4'd2,
        ST_LOAD_C = 4'd3,
        ST_LOAD_D = 4'd4,
        ST_RND_C  = 4'd5,
        ST_RND_A  = 4'd6,
        ST_FIN_D  = 4'd7,
        ST_FIN_B  = 4'd8
    } rbd_state_e;

    // Words per cipher block.
    localparam int BLK_WORDS = 4;

    // Number of operand lanes feeding the quadratic mixers (t and u).
    localparam int MIX_LANES = 2;

endpackage

// File: rtl/rbd_ctrl.sv
module rbd_ctrl
    import rbd_pkg::*;
#(
    parameter int ROUNDS = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    output rbd_state_e state_o,
    output logic       ready_o,
    output logic       drain_ld_o
);

    localparam int CNT_W = $clog2(ROUNDS + 1);

    rbd_state_e        state_q;
    rbd_state_e        state_d;
    logic [CNT_W-1:0]  rnd_q;
    logic [CNT_W-1:0]  rnd_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rnd_q   <= '0;
        end else begin
            state_q <= state_d;
            rnd_q   <= rnd_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        rnd_d   = rnd_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_LOAD_A;
                end
            end
            ST_LOAD_A: state_d = ST_LOAD_B;
            ST_LOAD_B: state_d = ST_LOAD_C;
            ST_LOAD_C: state_d = ST_LOAD_D;
            ST_LOAD_D: begin
                state_d = ST_RND_C;
                rnd_d   = CNT_W'(ROUNDS);
            end
            ST_RND_C: state_d = ST_RND_A;
            ST_RND_A: begin
                if (rnd_q == CNT_W'(1)) begin
                    state_d = ST_FIN_D;
                end else begin
                    state_d = ST_RND_C;
                    rnd_d   = rnd_q - CNT_W'(1);
                end
            end
            ST_FIN_D: state_d = ST_FIN_B;
            ST_FIN_B: state_d = start_i ? ST_LOAD_A : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        state_o    = state_q;
        ready_o    = (state_q == ST_IDLE) || (state_q == ST_FIN_B);
        drain_ld_o = (state_q == ST_FIN_B);
    end

endmodule

// File: rtl/rbd_quad.sv
module rbd_quad #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] f_o
);

    localparam int LG = $clog2(W);

    logic [W-1:0] prod;

    // x*(2x+1) modulo 2^W, then rotated left by log2(W).
    always_comb begin
        prod = x_i * {x_i[W-2:0], 1'b1};
        f_o  = {prod[W-LG-1:0], prod[W-1:W-LG]};
    end

endmodule

// File: rtl/rbd_mix.sv
module rbd_mix
    import rbd_pkg::*;
#(
    parameter int W = 16
) (
    input  rbd_state_e   state_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] ct_i,
    input  logic [W-1:0] key_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output logic [W-1:0] c_o,
    output logic [W-1:0] d_o
);

    localparam int LG = $clog2(W);

    logic [W-1:0] qsrc [MIX_LANES];
    logic [W-1:0] qval [MIX_LANES];
    logic [W-1:0] t_val;
    logic [W-1:0] u_val;

    function automatic logic [W-1:0] rot_r(input logic [W-1:0] x, input logic [LG-1:0] s);
        logic [2*W-1:0] dbl;
        dbl = {x, x} >> s;
        return dbl[W-1:0];
    endfunction

    // Lane 0 yields t, lane 1 yields u. In the first half of a round the
    // operands are the words that the register rotation is about to move into B and D.
    always_comb begin
        if (state_i == ST_RND_C) begin
            qsrc[0] = a_i;
            qsrc[1] = c_i;
        end else begin
            qsrc[0] = b_i;
            qsrc[1] = d_i;
        end
    end

    generate
        for (genvar g = 0; g < MIX_LANES; g++) begin : g_lane
            rbd_quad #(.W(W)) u_quad (
                .x_i (qsrc[g]),
                .f_o (qval[g])
            );
        end
    endgenerate

    assign t_val = qval[0];
    assign u_val = qval[1];

    always_comb begin
        a_o = a_i;
        b_o = b_i;
        c_o = c_i;
        d_o = d_i;
        unique case (state_i)
            ST_LOAD_A: a_o = ct_i;
            ST_LOAD_B: b_o = ct_i;
            ST_LOAD_C: c_o = ct_i - key_i;
            ST_LOAD_D: begin
                d_o = ct_i;
                a_o = a_i - key_i;
            end
            ST_RND_C: begin
                a_o = d_i;
                b_o = a_i;
                c_o = rot_r(b_i - key_i, t_val[LG-1:0]) ^ u_val;
                d_o = c_i;
            end
            ST_RND_A: a_o = rot_r(a_i - key_i, u_val[LG-1:0]) ^ t_val;
            ST_FIN_D: d_o = d_i - key_i;
            ST_FIN_B: b_o = b_i - key_i;
            default: begin
                a_o = a_i;
            end
        endcase
    end

endmodule

// File: rtl/rbd_drain.sv
module rbd_drain #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [N*W-1:0] blk_i,
    output logic [W-1:0] word_o
);

    logic [W-1:0] slot [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            if (i == N - 1) begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) begin
                        slot[i] <= '0;
                    end else if (load_i) begin
                        slot[i] <= blk_i[(N-1-i)*W +: W];
                    end else begin
                        slot[i] <= '0;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) begin
                        slot[i] <= '0;
                    end else if (load_i) begin
                        slot[i] <= blk_i[(N-1-i)*W +: W];
                    end else begin
                        slot[i] <= slot[i+1];
                    end
                end
            end
        end
    endgenerate

    assign word_o = slot[0];

endmodule

// File: rtl/rot_block_decryptor.sv
module rot_block_decryptor
    import rbd_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ROUNDS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_in,
    input  logic [WORD_W-1:0] cipher_in,
    input  logic [WORD_W-1:0] rkey_in,
    output logic [WORD_W-1:0] plain_out,
    output logic              ready_out
);

    localparam int BLK_W = BLK_WORDS * WORD_W;

    rbd_state_e        state;
    logic              drain_ld;
    logic [WORD_W-1:0] a_q, b_q, c_q, d_q;
    logic [WORD_W-1:0] a_n, b_n, c_n, d_n;
    logic [BLK_W-1:0]  final_blk;

    rbd_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_in),
        .state_o    (state),
        .ready_o    (ready_out),
        .drain_ld_o (drain_ld)
    );

    rbd_mix #(.W(WORD_W)) u_mix (
        .state_i (state),
        .a_i     (a_q),
        .b_i     (b_q),
        .c_i     (c_q),
        .d_i     (d_q),
        .ct_i    (cipher_in),
        .key_i   (rkey_in),
        .a_o     (a_n),
        .b_o     (b_n),
        .c_o     (c_n),
        .d_o     (d_n)
    );

    // Working registers A..D.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= '0;
            d_q <= '0;
        end else begin
            a_q <= a_n;
            b_q <= b_n;
            c_q <= c_n;
            d_q <= d_n;
        end
    end

    assign final_blk = {a_n, b_n, c_n, d_n};

    rbd_drain #(.W(WORD_W), .N(BLK_WORDS)) u_drain (
        .clk    (clk),
        .rst    (rst),
        .load_i (drain_ld),
        .blk_i  (final_blk),
        .word_o (plain_out)
    );

endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
    parameter int WORD_W = 16,
    parameter int ROUNDS = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              start_in,
    input logic              ready_out,
    input logic [WORD_W-1:0] plain_out
);

    localparam int BUSY = 2 * ROUNDS + 5;
    localparam int LC_W = $clog2(BUSY + 2);

    logic [LC_W-1:0] lowcnt;

    always_ff @(posedge clk) begin
        if (rst || ready_out) begin
            lowcnt <= '0;
        end else if (lowcnt != LC_W'(BUSY + 1)) begin
            lowcnt <= lowcnt + LC_W'(1);
        end
    end

    AST_RESET_READY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ready_out);  // R1

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (plain_out == '0));  // R1

    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        (ready_out && start_in) |=> !ready_out);  // R5

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready_out) && !$past(rst)) |-> (lowcnt == LC_W'(BUSY)));  // R5

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ready_out && (lowcnt < LC_W'(BUSY - 1))) |=> !ready_out);  // R8

endmodule

bind rot_block_decryptor rbd_checker #(.WORD_W(WORD_W), .ROUNDS(ROUNDS)) u_rbd_checker (
    .clk       (clk),
    .rst       (rst),
    .start_in  (start_in),
    .ready_out (ready_out),
    .plain_out (plain_out)
);

// File: tb/test_rot_block_decryptor.sv
`timescale 1ns/1ps
module test_rot_block_decryptor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_in = 1'b0;
    logic [15:0] cipher_in = '0;
    logic [15:0] rkey_in = '0;
    logic [15:0] plain_out;
    logic        ready_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rot_block_decryptor i_rot_block_decryptor (
        .clk       (clk),
        .rst       (rst),
        .start_in  (start_in),
        .cipher_in (cipher_in),
        .rkey_in   (rkey_in),
        .plain_out (plain_out),
        .ready_out (ready_out)
    );

    // Stimulus table: {plaintext block, key seed}. Seed 0 = all-zero keys, seed 1 = all-ones keys.
    localparam logic [79:0] VEC [6] = '{
        {64'h0000_0000_0000_0000, 16'h0000},
        {64'hFFFF_FFFF_FFFF_FFFF, 16'h0001},
        {64'h0123_4567_89AB_CDEF, 16'h0001},
        {64'h8000_0001_7FFF_FFFE, 16'h0000},
        {64'hDEAD_BEEF_CAFE_F00D, 16'h1234},
        {64'h0F0F_F0F0_3C3C_C3C3, 16'hBEEF}
    };

    function automatic logic [15:0] key_of(input logic [15:0] seed, input int j);
        int v;
        if (seed == 16'h0000) return 16'h0000;
        if (seed == 16'h0001) return 16'hFFFF;
        v = int'(seed) * (j + 7) * 40503 + j * 257 + 22609;
        return v[15:0] ^ v[31:16];
    endfunction

    function automatic logic [15:0] rol16(input logic [15:0] x, input int s);
        logic [31:0] dbl;
        dbl = {x, x} << s;
        return dbl[31:16];
    endfunction

    function automatic logic [15:0] fq(input logic [15:0] x);
        logic [15:0] p;
        p = 16'(32'(x) * (32'(x) * 2 + 1));
        return rol16(p, 4);
    endfunction

    // Forward cipher model, written from the round definition.
    function automatic logic [63:0] encrypt(input logic [63:0] p, input logic [15:0] seed);
        logic [15:0] a, b, c, d, t, u, tmp;
        a = p[63:48]; b = p[47:32]; c = p[31:16]; d = p[15:0];
        b = b + key_of(seed, 0);
        d = d + key_of(seed, 1);
        for (int i = 1; i <= 20; i++) begin
            t = fq(b);
            u = fq(d);
            a = rol16(a ^ t, int'(u[3:0])) + key_of(seed, 2 * i);
            c = rol16(c ^ u, int'(t[3:0])) + key_of(seed, 2 * i + 1);
            tmp = a; a = b; b = c; c = d; d = tmp;
        end
        a = a + key_of(seed, 42);
        c = c + key_of(seed, 43);
        return {a, b, c, d};
    endfunction

    task automatic chk16(input logic [15:0] got, input logic [15:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_cnt(input int bad, input string req);
        n_chk++;
        if (bad != 0) begin
            n_bad++;
            $display("FAIL %s: actual %0d mismatching cycles expected 0", req, bad);
        end
    endtask

    // Runs one block, or two when gap > 0 (second start at cycle gap).
    // inj places a start pulse at cycle 20, while ready is low.
    task automatic run_blocks(input logic [63:0] p1, input logic [15:0] s1,
                              input logic [63:0] p2, input logic [15:0] s2,
                              input int gap, input bit inj, input string tag);
        logic [63:0] c1, c2;
        int last;
        int bad_rdy;
        int bad_zero;
        bit two;
        bit exp_rdy;
        logic [15:0] exp_out;
        bit in_w;
        two = (gap > 0);
        c1 = encrypt(p1, s1);
        c2 = encrypt(p2, s2);
        last = (two ? gap : 0) + 52;
        bad_rdy = 0;
        bad_zero = 0;
        for (int c = 0; c <= last; c++) begin
            @(negedge clk);
            // observe cycle c
            exp_rdy = !((c >= 1 && c <= 45) || (two && c >= gap + 1 && c <= gap + 45));
            if (ready_out !== exp_rdy) bad_rdy++;
            in_w = 1'b0;
            exp_out = 16'h0000;
            if (c >= 47 && c <= 50) begin
                in_w = 1'b1;
                exp_out = p1[63 - 16 * (c - 47) -: 16];
                chk16(plain_out, exp_out, {tag, " R2 R3 R4 R6 R10 block1 word"});
            end else if (two && c >= gap + 47 && c <= gap + 50) begin
                in_w = 1'b1;
                exp_out = p2[63 - 16 * (c - gap - 47) -: 16];
                chk16(plain_out, exp_out, {tag, " R4 R6 R9 block2 word"});
            end
            if (!in_w && plain_out !== 16'h0000) bad_zero++;
            // drive cycle c
            start_in  = (c == 0) || (two && c == gap) || (inj && c == 20);
            cipher_in = 16'hA5A5 ^ 16'(c * 16'h0313);
            rkey_in   = 16'h5A5A ^ 16'(c * 16'h0B07);
            if (c >= 1 && c <= 4) cipher_in = c1[63 - 16 * (c - 1) -: 16];
            if (c >= 3 && c <= 46) rkey_in = key_of(s1, 43 - (c - 3));
            if (two && c >= gap + 1 && c <= gap + 4) cipher_in = c2[63 - 16 * (c - gap - 1) -: 16];
            if (two && c >= gap + 3 && c <= gap + 46) rkey_in = key_of(s2, 43 - (c - gap - 3));
        end
        start_in = 1'b0;
        chk_cnt(bad_rdy, {tag, " R5 ready timing"});
        chk_cnt(bad_zero, {tag, " R7 quiet output"});
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk16({15'd0, ready_out}, 16'h0001, "R1 ready after reset");
        chk16(plain_out, 16'h0000, "R1 output after reset");

        // Table walk
        for (int k = 0; k < 6; k++) begin
            run_blocks(VEC[k][79:16], VEC[k][15:0], 64'h0, 16'h0, 0, 1'b0, "table");
        end

        // R8: start while busy is ignored
        run_blocks(64'h1357_9BDF_2468_ACE0, 16'h4321, 64'h0, 16'h0, 0, 1'b1, "R8 busy start");

        // R9: back-to-back start in the cycle ready returns
        run_blocks(64'hAAAA_5555_0001_8000, 16'h0777, 64'h7654_3210_FEDC_BA98, 16'h0001,
                   46, 1'b0, "R9 back-to-back");
        run_blocks(64'h0000_FFFF_0000_FFFF, 16'h0000, 64'h1111_2222_3333_4444, 16'h9999,
                   60, 1'b0, "gap60");

        // R1: reset in the middle of a block
        @(negedge clk);
        start_in = 1'b1;
        cipher_in = 16'h1234;
        @(negedge clk);
        start_in = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk16({15'd0, ready_out}, 16'h0001, "R1 ready after mid-block reset");
        chk16(plain_out, 16'h0000, "R1 output after mid-block reset");
        repeat (60) begin
            @(negedge clk);
            if (plain_out !== 16'h0000) begin
                chk16(plain_out, 16'h0000, "R1 abandoned block output");
            end
        end
        run_blocks(64'hC001_D00D_0BAD_F00D, 16'h2468, 64'h0, 16'h0, 0, 1'b0, "R1 after reset");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule